// File: doc/BRIEF.md
# Cycle Counter Compare Timer

This block keeps a free-running cycle count and a set of compare values. Each step, the count moves forward by a small delta chosen by the surrounding logic. The step need not be 1, so a batch of idle cycles can be applied at once. Every compare value is tested against the span the count just crossed. A match raises that comparator's own interrupt line, and the line stays high until its compare value is written again.

A second output gives the compare value that the count will reach first. When no comparators are built, this output is the count minus one, which is a full turn of the counter away. A parent can use it to decide how far it may safely advance the count in one step. The mapping of interrupt lines to interrupt numbers lives outside this block.

A parameter removes the comparators altogether. The counter then keeps counting and no interrupt is ever raised.

Top module: `cyc_cmp_timer`

## Requirements
- R1: After synchronous reset, `count` is 0, every `irq` bit is 0 and every compare value is 0, so `wake_cnt` reads 0.
- R2: When `adv_en` is high and no counter write is taking place, `count` becomes `count + adv_delta` modulo 2^32 at the next edge. When `adv_en` is low and there is no write, `count` holds its value.
- R3: A write with `wr_sel` = 0 loads `wr_data` into the count. It takes priority over an advance in the same cycle: that advance is dropped and no comparator is tested in that cycle.
- R4: For an applied advance, `irq[i]` is set at the next edge when (compare_i − count before the step) mod 2^32 ≤ `adv_delta`. This includes steps that wrap past 2^32. It also includes a delta of 0 when compare_i equals the count.
- R5: Once set, `irq[i]` stays high across later cycles until compare_i is written.
- R6: A write with `wr_sel` = i+1 loads compare_i and clears `irq[i]`. If a match for the old compare value happens in the same cycle, the clear wins.
- R7: `wake_cnt` is the compare value with the smallest (compare − count) mod 2^32. When two distances are equal, the lowest index wins. Count − 1 is used when no compare value is nearer than that.
- R8: With `TIMER_EN` = 0, the counter still follows R2 and R3. `irq` stays 0 and `wake_cnt` is `count` − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Apply an advance this cycle |
| adv_delta | input | DW (8) | Amount to add to the count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SELW (2) | 0 selects the count, i+1 selects compare i |
| wr_data | input | CW (32) | Write value |
| count | output | CW (32) | Current cycle count |
| irq | output | NCMP (3) | One sticky interrupt per comparator |
| wake_cnt | output | CW (32) | Nearest upcoming compare value |

## Verification
Directed steps cover the following cases:
- a wrap of the count past 2^32 that must still catch a compare near zero;
- a zero delta landing exactly on a compare;
- compare values at exactly `count + delta` and one beyond it, which separate ≤ from <;
- writes to the count or a compare in the same cycle as a matching advance, which show which side wins.

Random steps then mix deltas of 0 to 255 with compare values placed a short distance ahead of the count. This produces frequent hits and misses near the edge of the window, and it exercises the tie and ordering rules of the nearest-compare output.

A second instance built without comparators runs on the same stimulus. It shows that the count is unaffected by that option.

// File: rtl/cct_pkg.sv
package cct_pkg;
  // modular distance from a to b going forward
  function automatic logic [31:0] fwd_dist(input logic [31:0] to_v, input logic [31:0] from_v);
    return to_v - from_v;
  endfunction
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CW = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          adv,
  input  logic [DW-1:0] delta,
  output logic [CW-1:0] cnt
);
  localparam int PADW = CW - DW;

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (adv) cnt <= cnt + {{PADW{1'b0}}, delta};
  end

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ld) && !$past(rst) |-> cnt == $past(ld_val));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ld) && !$past(adv) && !$past(rst) |-> $stable(cnt));
endmodule

// File: rtl/cct_cmp_unit.sv
module cct_cmp_unit #(
  parameter int CW = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] delta,
  input  logic          adv_ok,
  input  logic          wr,
  input  logic [CW-1:0] wr_val,
  output logic [CW-1:0] cmp_val,
  output logic          irq
);
  import cct_pkg::*;
  localparam int PADW = CW - DW;

  logic [CW-1:0] gap;
  logic          hit;

  always_comb begin
    gap = fwd_dist(cmp_val, cnt);
    hit = adv_ok && (gap <= {{PADW{1'b0}}, delta});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val <= '0;
      irq     <= 1'b0;
    end else if (wr) begin
      cmp_val <= wr_val;
      irq     <= 1'b0;
    end else if (hit) begin
      irq     <= 1'b1;
    end
  end

  // R4
  rise_needs_adv_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(adv_ok));
  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    irq && !wr |=> irq);
  // R6
  wr_clears_chk: assert property (@(posedge clk) disable iff (rst)
    wr |=> !irq);
endmodule

// File: rtl/cct_wake.sv
module cct_wake #(
  parameter int CW   = 32,
  parameter int NCMP = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CW-1:0]             cnt,
  input  logic [NCMP-1:0][CW-1:0]   cmps,
  output logic [CW-1:0]             wake
);
  import cct_pkg::*;

  always_comb begin
    wake = cnt - 1'b1;
    for (int i = 0; i < NCMP; i++) begin
      if (fwd_dist(cmps[i], cnt) < fwd_dist(wake, cnt))
        wake = cmps[i];
    end
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_chk
    // R7
    nearest_chk: assert property (@(posedge clk) disable iff (rst)
      fwd_dist(wake, cnt) <= fwd_dist(cmps[g], cnt));
  end
endmodule

// File: rtl/cyc_cmp_timer.sv
module cyc_cmp_timer #(
  parameter int CW       = 32,
  parameter int DW       = 8,
  parameter int NCMP     = 3,
  parameter bit TIMER_EN = 1'b1,
  localparam int SELW    = $clog2(NCMP + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_en,
  input  logic [DW-1:0]   adv_delta,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_sel,
  input  logic [CW-1:0]   wr_data,
  output logic [CW-1:0]   count,
  output logic [NCMP-1:0] irq,
  output logic [CW-1:0]   wake_cnt
);
  logic cnt_wr;
  logic adv_ok;

  assign cnt_wr = wr_en && (wr_sel == '0);
  assign adv_ok = adv_en && !cnt_wr;

  cct_counter #(.CW(CW), .DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .ld(cnt_wr), .ld_val(wr_data),
    .adv(adv_ok), .delta(adv_delta), .cnt(count)
  );

  if (TIMER_EN) begin : g_timer
    logic [NCMP-1:0][CW-1:0] cmp_q;
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      logic sel_i;
      assign sel_i = wr_en && (wr_sel == SELW'(i + 1));
      cct_cmp_unit #(.CW(CW), .DW(DW)) u_cmp (
        .clk(clk), .rst(rst), .cnt(count), .delta(adv_delta),
        .adv_ok(adv_ok), .wr(sel_i), .wr_val(wr_data),
        .cmp_val(cmp_q[i]), .irq(irq[i])
      );
    end
    cct_wake #(.CW(CW), .NCMP(NCMP)) u_wake (
      .clk(clk), .rst(rst), .cnt(count), .cmps(cmp_q), .wake(wake_cnt)
    );
  end else begin : g_no_timer
    assign irq      = '0;
    assign wake_cnt = count - 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> count == '0 && irq == '0);
endmodule

// File: tb/tb_cyc_cmp_timer.sv
module tb_cyc_cmp_timer;
  localparam int NC = 3;
  localparam int SW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk; // 20 ns period, 50 MHz

  logic          rst, adv_en, wr_en;
  logic [7:0]    adv_delta;
  logic [SW-1:0] wr_sel;
  logic [31:0]   wr_data;
  logic [31:0]   count, wake_cnt, count_off, wake_off;
  logic [NC-1:0] irq, irq_off;

  cyc_cmp_timer #(.NCMP(NC)) dut (
    .clk(clk), .rst(rst), .adv_en(adv_en), .adv_delta(adv_delta),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count(count), .irq(irq), .wake_cnt(wake_cnt)
  );

  cyc_cmp_timer #(.NCMP(NC), .TIMER_EN(1'b0)) dut_off (
    .clk(clk), .rst(rst), .adv_en(adv_en), .adv_delta(adv_delta),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count(count_off), .irq(irq_off), .wake_cnt(wake_off)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0]   m_cnt;
  logic [31:0]   m_cmp [NC];
  logic [NC-1:0] m_irq;

  function automatic logic [31:0] m_wake();
    logic [31:0] w;
    w = m_cnt - 32'd1;
    for (int i = 0; i < NC; i++) begin
      logic [31:0] d_i, d_w;
      d_i = m_cmp[i] - m_cnt;
      d_w = w - m_cnt;
      if (d_i < d_w) w = m_cmp[i];
    end
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic step(input logic adv, input logic [7:0] dl, input logic wr,
                      input logic [SW-1:0] sel, input logic [31:0] data,
                      input string t_cnt, input string t_irq);
    logic          cw, aok;
    logic [31:0]   n_cnt;
    logic [31:0]   n_cmp [NC];
    logic [NC-1:0] n_irq;
    adv_en = adv; adv_delta = dl; wr_en = wr; wr_sel = sel; wr_data = data;
    cw  = wr && (sel == 0);
    aok = adv && !cw;
    n_cnt = cw ? data : (aok ? m_cnt + {24'd0, dl} : m_cnt);
    n_irq = m_irq;
    for (int i = 0; i < NC; i++) begin
      logic [31:0] g;
      n_cmp[i] = m_cmp[i];
      g = m_cmp[i] - m_cnt;
      if (aok && g <= {24'd0, dl}) n_irq[i] = 1'b1;
      if (wr && int'(sel) == i + 1) begin
        n_cmp[i] = data;
        n_irq[i] = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    m_cnt = n_cnt; m_irq = n_irq;
    for (int i = 0; i < NC; i++) m_cmp[i] = n_cmp[i];
    adv_en = 0; wr_en = 0;
    chk(t_cnt, count, m_cnt);
    chk(t_irq, {29'd0, irq}, {29'd0, m_irq});
    chk("R7", wake_cnt, m_wake());
    chk("R8", count_off, m_cnt);
    chk("R8", {29'd0, irq_off}, 32'd0);
    chk("R8", wake_off, m_cnt - 32'd1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; adv_en = 0; adv_delta = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    m_cnt = 0; m_irq = 0;
    for (int i = 0; i < NC; i++) m_cmp[i] = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", count, 32'd0);
    chk("R1", {29'd0, irq}, 32'd0);
    chk("R1", wake_cnt, 32'd0);

    // R4: all compares at 0, first step from 0 hits them
    step(1, 8'd5, 0, 0, 0, "R2", "R4");
    // R5: no write, lines stay high
    step(1, 8'd3, 0, 0, 0, "R2", "R5");
    step(0, 8'd50, 0, 0, 0, "R2", "R5");
    // R6: compare write clears; then clear beats same-cycle match
    step(0, 0, 1, 2'd2, m_cnt + 32'd2, "R2", "R6");
    step(1, 8'd5, 1, 2'd2, 32'h1234_0000, "R2", "R6");
    // R3: counter write overrides a matching advance
    step(0, 0, 1, 2'd1, m_cnt + 32'd3, "R2", "R6");
    step(1, 8'd10, 1, 2'd0, 32'hFFFF_FFF0, "R3", "R3");
    // R4 wraparound: compare near zero reached across 2^32
    step(0, 0, 1, 2'd3, 32'd5, "R2", "R6");
    step(1, 8'd255, 0, 0, 0, "R2", "R4");
    // R4 delta zero equal hit, and +1 miss
    step(0, 0, 1, 2'd2, m_cnt, "R2", "R6");
    step(0, 0, 1, 2'd1, m_cnt + 32'd1, "R2", "R6");
    step(1, 8'd0, 0, 0, 0, "R2", "R4");
    // R4 window edge: exactly delta hits, delta+1 misses
    step(0, 0, 1, 2'd1, m_cnt + 32'd7, "R2", "R6");
    step(0, 0, 1, 2'd2, m_cnt + 32'd8, "R2", "R6");
    step(1, 8'd7, 0, 0, 0, "R2", "R4");
    // R7 tie: two compares equal, lowest index
    step(0, 0, 1, 2'd1, m_cnt + 32'd40, "R2", "R7");
    step(0, 0, 1, 2'd3, m_cnt + 32'd40, "R2", "R7");

    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [7:0]  d;
      logic [31:0] v;
      r = int'($urandom_range(0, 99));
      d = (r < 10) ? 8'd0 : 8'($urandom_range(0, 255));
      v = m_cnt + 32'($urandom_range(0, 300));
      if (r < 50)      step(1, d, 0, 0, 0, "R2", "R4");
      else if (r < 80) step(1, d, 1, 2'($urandom_range(1, NC)), v, "R2", "R6");
      else if (r < 85) step(1, d, 1, 2'd0, $urandom, "R3", "R3");
      else             step(0, d, 0, 0, 0, "R2", "R5");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule